// File: doc/BRIEF.md
# Two-Wire Serial Memory Discovery Sequencer

This block drives a byte-level two-wire bus engine at boot time to find a serial memory and open a sequential read from it. It waits for an idle bus, takes it with START, and then probes a window of seven-bit device addresses. Between probes it uses RESTART and never releases the bus. When a device acknowledges its write-address byte, the sequencer writes a zero start location, issues RESTART, and addresses the same device for reading.

A dummy 0xFF transfer fetches the first data byte. Each byte that comes back is handed to a consumer as a one-cycle strobe and is then sent back to the engine, which clocks in the next byte. A jump request or a return request ends the stream. Both issue STOP. After a jump the engine enable is also dropped. The engine's clock divisor is chosen from a configuration pin that is captured while reset is held.

Top module: `twi_probe_seq`

## Requirements
- R1: After reset no command is requested while `bus_busy` is high; the first command after the bus is seen free is START (op code 0).
- R2: The first probe is a transfer (op code 3) of byte 0xA0, which is device 0x50 with bit 0 = 0 for write. Each probe without acknowledge is followed by RESTART (op code 1) and a probe of the next address.
- R3: The probe window covers SCAN_N addresses from the base. After the last one (0x57) the scan wraps to 0x50 and continues without limit.
- R4: After a probe is acknowledged, PTR_BYTES transfers of 0x00 follow.
- R5: A missing acknowledge on a pointer byte or on the read-address byte causes STOP (op code 2). The sequencer then waits for the bus to be free, issues START, and restarts the scan at 0x50.
- R6: After the pointer bytes are acknowledged, RESTART follows, then a transfer of {answering address, 1}.
- R7: Reading begins with a transfer of 0xFF. Every completed read transfer puts its received byte on `byte_data` with `byte_valid` high for exactly the cycle after `cmd_done`. That byte is the data of the next transfer.
- R8: A jump request seen during reading lets the current transfer finish and its byte be delivered. STOP follows. When that STOP completes, `eng_en` goes low and no further command is requested.
- R9: A return request seen during reading behaves like R8, except that `eng_en` stays high after STOP. No further command is requested.
- R10: `clk_div` is 16 if `cfg_slow` was 0 during reset and 160 if it was 1. Changes of `cfg_slow` after reset have no effect.
- R11: A request stays high, with `cmd_op` and `cmd_wdata` held stable, until the cycle in which `cmd_done` is high. `cmd_ack` and `cmd_rdata` are read only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; `cfg_slow` is captured while high |
| cfg_slow | input | 1 | Divisor select, sampled during reset |
| bus_busy | input | 1 | Engine reports the bus as occupied |
| cmd_done | input | 1 | Engine finished the requested command (one cycle) |
| cmd_ack | input | 1 | Acknowledge status, valid with `cmd_done` |
| cmd_rdata | input | 8 | Byte received during a transfer, valid with `cmd_done` |
| jump_req | input | 1 | End reading, stop, and shut the interface off |
| ret_req | input | 1 | End reading with STOP only |
| cmd_req | output | 1 | Command request to the engine |
| cmd_op | output | 2 | 0 START, 1 RESTART, 2 STOP, 3 byte transfer |
| cmd_wdata | output | 8 | Byte to send in a transfer |
| eng_en | output | 1 | Engine enable |
| clk_div | output | DIV_W | Engine clock divisor |
| byte_valid | output | 1 | Received byte strobe |
| byte_data | output | 8 | Received byte |

## Verification
The bench uses the default parameters: a window of eight addresses from 0x50, two pointer bytes, and divisors 16 and 160. It pairs them with an engine model that completes every command four cycles after taking it. The eight-entry window lets one run fail nine probes and confirm the wrap back to 0x50, and another fail all eight and be answered at the base on the second lap. Two pointer bytes leave room to reject the first byte after a device at a later address has answered, which shows the retry restarting from the base. The two divisor values tell the captured configuration apart from a later change of the pin.

// File: rtl/twi_probe_pkg.sv
package twi_probe_pkg;

   typedef enum logic [1:0] {
      OP_START   = 2'd0,
      OP_RESTART = 2'd1,
      OP_STOP    = 2'd2,
      OP_XFER    = 2'd3
   } twi_op_e;

   typedef enum logic [3:0] {
      S_FREE,
      S_START,
      S_PROBE,
      S_RESCAN,
      S_PTR,
      S_RESTART_RD,
      S_RDADDR,
      S_XFER,
      S_STOP_RETRY,
      S_STOP_JMP,
      S_STOP_RET,
      S_OFF,
      S_PARK
   } seq_state_e;

   localparam logic [7:0] DUMMY_BYTE = 8'hFF;

endpackage

// File: rtl/twi_div_sel.sv
module twi_div_sel #(
   parameter int DIV_W    = 8,
   parameter int DIV_FAST = 16,
   parameter int DIV_SLOW = 160
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_slow,
   output logic [DIV_W-1:0] clk_div
);

   if (DIV_FAST >= (1 << DIV_W) || DIV_SLOW >= (1 << DIV_W)) begin : g_bad_w
      $error("divisor does not fit in DIV_W");
   end

   if (DIV_FAST == DIV_SLOW) begin : g_fixed
      assign clk_div = DIV_W'(DIV_FAST);
   end else begin : g_sel
      logic sel_q;

      always_ff @(posedge clk) begin
         if (rst) sel_q <= cfg_slow;
      end

      assign clk_div = sel_q ? DIV_W'(DIV_SLOW) : DIV_W'(DIV_FAST);

      assert_div_hold_R10: assert property (@(posedge clk) disable iff (rst)
         !rst |=> $stable(clk_div));
   end

endmodule

// File: rtl/twi_addr_scan.sv
module twi_addr_scan #(
   parameter logic [6:0] DEV_BASE = 7'h50,
   parameter int         SCAN_N   = 8
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       clr,
   input  logic       step,
   output logic [6:0] addr
);

   localparam int IDX_W = (SCAN_N > 1) ? $clog2(SCAN_N) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(SCAN_N - 1);

   if (SCAN_N < 1 || int'(DEV_BASE) + SCAN_N > 128) begin : g_bad_n
      $error("scan window leaves the 7-bit address space");
   end

   logic [IDX_W-1:0] idx_q;

   if ((1 << IDX_W) == SCAN_N) begin : g_pow2
      always_ff @(posedge clk) begin
         if (rst || clr) idx_q <= '0;
         else if (step)  idx_q <= idx_q + 1'b1;
      end
   end else begin : g_cmp
      always_ff @(posedge clk) begin
         if (rst || clr) idx_q <= '0;
         else if (step)  idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      end
   end

   assign addr = DEV_BASE + 7'(idx_q);

   assert_scan_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      (step && !clr && idx_q == LAST) |=> addr == DEV_BASE);

   assert_scan_clear_R5: assert property (@(posedge clk) disable iff (rst)
      clr |=> addr == DEV_BASE);

endmodule

// File: rtl/twi_probe_seq.sv
module twi_probe_seq
   import twi_probe_pkg::*;
#(
   parameter logic [6:0] DEV_BASE  = 7'h50,
   parameter int         SCAN_N    = 8,
   parameter int         PTR_BYTES = 2,
   parameter int         DIV_W     = 8,
   parameter int         DIV_FAST  = 16,
   parameter int         DIV_SLOW  = 160
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_slow,
   input  logic             bus_busy,
   input  logic             cmd_done,
   input  logic             cmd_ack,
   input  logic [7:0]       cmd_rdata,
   input  logic             jump_req,
   input  logic             ret_req,
   output logic             cmd_req,
   output logic [1:0]       cmd_op,
   output logic [7:0]       cmd_wdata,
   output logic             eng_en,
   output logic [DIV_W-1:0] clk_div,
   output logic             byte_valid,
   output logic [7:0]       byte_data
);

   localparam int PTR_W = $clog2(PTR_BYTES) + 1;
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(PTR_BYTES - 1);

   if (PTR_BYTES < 1) begin : g_bad_ptr
      $error("PTR_BYTES must be at least 1");
   end

   seq_state_e       st_q;
   logic [PTR_W-1:0] ptr_cnt;
   logic [7:0]       tx_q;
   logic             jmp_pend, ret_pend;
   logic             scan_step, scan_clr;
   logic [6:0]       dev_addr;
   twi_op_e          op_e;

   twi_div_sel #(.DIV_W(DIV_W), .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) i_div (
      .clk(clk), .rst(rst), .cfg_slow(cfg_slow), .clk_div(clk_div));

   twi_addr_scan #(.DEV_BASE(DEV_BASE), .SCAN_N(SCAN_N)) i_scan (
      .clk(clk), .rst(rst), .clr(scan_clr), .step(scan_step), .addr(dev_addr));

   assign scan_step = (st_q == S_PROBE) && cmd_done && !cmd_ack;
   assign scan_clr  = (st_q == S_STOP_RETRY) && cmd_done;
   assign eng_en    = (st_q != S_OFF);
   assign cmd_op    = op_e;

   always_comb begin
      cmd_req   = 1'b1;
      op_e      = OP_XFER;
      cmd_wdata = 8'h00;
      unique case (st_q)
         S_START:      op_e = OP_START;
         S_PROBE:      cmd_wdata = {dev_addr, 1'b0};
         S_RESCAN:     op_e = OP_RESTART;
         S_PTR:        cmd_wdata = 8'h00;
         S_RESTART_RD: op_e = OP_RESTART;
         S_RDADDR:     cmd_wdata = {dev_addr, 1'b1};
         S_XFER:       cmd_wdata = tx_q;
         S_STOP_RETRY, S_STOP_JMP, S_STOP_RET: op_e = OP_STOP;
         default: begin
            cmd_req = 1'b0;
            op_e    = OP_STOP;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q       <= S_FREE;
         ptr_cnt    <= '0;
         tx_q       <= DUMMY_BYTE;
         jmp_pend   <= 1'b0;
         ret_pend   <= 1'b0;
         byte_valid <= 1'b0;
         byte_data  <= 8'h00;
      end else begin
         byte_valid <= 1'b0;
         if (st_q == S_XFER) begin
            if (jump_req) jmp_pend <= 1'b1;
            if (ret_req)  ret_pend <= 1'b1;
         end
         unique case (st_q)
            S_FREE:   if (!bus_busy) st_q <= S_START;
            S_START:  if (cmd_done) st_q <= S_PROBE;
            S_PROBE:
               if (cmd_done) begin
                  if (cmd_ack) begin
                     st_q    <= S_PTR;
                     ptr_cnt <= '0;
                  end else begin
                     st_q <= S_RESCAN;
                  end
               end
            S_RESCAN: if (cmd_done) st_q <= S_PROBE;
            S_PTR:
               if (cmd_done) begin
                  if (!cmd_ack)                st_q <= S_STOP_RETRY;
                  else if (ptr_cnt == PTR_LAST) st_q <= S_RESTART_RD;
                  else                          ptr_cnt <= ptr_cnt + 1'b1;
               end
            S_RESTART_RD: if (cmd_done) st_q <= S_RDADDR;
            S_RDADDR:
               if (cmd_done) begin
                  if (cmd_ack) begin
                     st_q <= S_XFER;
                     tx_q <= DUMMY_BYTE;
                  end else begin
                     st_q <= S_STOP_RETRY;
                  end
               end
            S_XFER:
               if (cmd_done) begin
                  byte_valid <= 1'b1;
                  byte_data  <= cmd_rdata;
                  tx_q       <= cmd_rdata;
                  if (jmp_pend || jump_req)     st_q <= S_STOP_JMP;
                  else if (ret_pend || ret_req) st_q <= S_STOP_RET;
               end
            S_STOP_RETRY: if (cmd_done) st_q <= S_FREE;
            S_STOP_JMP:   if (cmd_done) st_q <= S_OFF;
            S_STOP_RET:   if (cmd_done) st_q <= S_PARK;
            default: ;
         endcase
      end
   end

   assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
      (cmd_req && !cmd_done) |=> cmd_req && $stable(cmd_op) && $stable(cmd_wdata));

   assert_start_free_R1: assert property (@(posedge clk) disable iff (rst)
      ($rose(cmd_req) && cmd_op == OP_START) |-> $past(!bus_busy));

   assert_byte_after_done_R7: assert property (@(posedge clk) disable iff (rst)
      byte_valid |-> $past(cmd_done) && $past(cmd_op) == OP_XFER);

   assert_off_after_stop_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(eng_en) |-> $past(cmd_done) && $past(cmd_op) == OP_STOP);

   assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      !eng_en |-> !cmd_req);

endmodule

// File: tb/test_twi_probe_seq.sv
`timescale 1ns/1ps
module test_twi_probe_seq;
   import twi_probe_pkg::*;

   localparam logic [6:0] BASE = 7'h50;
   localparam int LAT = 4;

   logic       clk = 1'b0;
   logic       rst, cfg_slow, bus_busy, cmd_done, cmd_ack, jump_req, ret_req;
   logic [7:0] cmd_rdata;
   logic       cmd_req, eng_en, byte_valid;
   logic [1:0] cmd_op;
   logic [7:0] cmd_wdata, clk_div, byte_data;

   twi_probe_seq i_twi_probe_seq (
      .clk(clk), .rst(rst), .cfg_slow(cfg_slow), .bus_busy(bus_busy),
      .cmd_done(cmd_done), .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata),
      .jump_req(jump_req), .ret_req(ret_req), .cmd_req(cmd_req),
      .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .eng_en(eng_en),
      .clk_div(clk_div), .byte_valid(byte_valid), .byte_data(byte_data));

   always #2 clk = ~clk;

   int total = 0, bad = 0;
   bit fin = 0;

   logic [9:0] exp_q[$];
   string      tag_q[$];
   int  probe_no, n_ack, ptr_fail_left, phase, ptr_seen, sidx, got, cnt, cls;
   bit  active, run_on, busy_chk, exp_en, jump_mode;
   logic [1:0] cap_op;
   logic [7:0] cap_data, last_rx, exp_div;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] rx_of(input int k);
      return 8'h3C + 8'(k * 7);
   endfunction

   task automatic push(input logic [1:0] op, input logic [7:0] d, input string t);
      exp_q.push_back({op, d});
      tag_q.push_back(t);
   endtask

   task automatic build(input int na, input int pf, input int nb, input bit jmp);
      logic [6:0] a;
      push(OP_START, 8'h00, "R1");
      for (int p = 0; p <= na; p++) begin
         push(OP_XFER, {BASE + 7'(p % 8), 1'b0}, (p >= 8) ? "R3" : "R2");
         if (p < na) push(OP_RESTART, 8'h00, "R2");
      end
      a = BASE + 7'(na % 8);
      if (pf > 0) begin
         push(OP_XFER, 8'h00, "R4");
         push(OP_STOP, 8'h00, "R5");
         push(OP_START, 8'h00, "R5");
         push(OP_XFER, {BASE, 1'b0}, "R5");
         a = BASE;
      end
      push(OP_XFER, 8'h00, "R4");
      push(OP_XFER, 8'h00, "R4");
      push(OP_RESTART, 8'h00, "R6");
      push(OP_XFER, {a, 1'b1}, "R6");
      push(OP_XFER, 8'hFF, "R7");
      for (int k = 0; k < nb; k++) push(OP_XFER, rx_of(k), "R7");
      push(OP_STOP, 8'h00, jmp ? "R8" : "R9");
   endtask

   // engine model and per-clock reference comparison
   always @(negedge clk) begin
      if (run_on && !fin) begin
         chk(clk_div == exp_div, "R10", clk_div, exp_div);
         if (cmd_done) begin
            cmd_done = 1'b0;
            active   = 1'b0;
            if (cap_op == OP_STOP && cls == 4 && jump_mode) exp_en = 1'b0;
            if (cls == 3) begin
               chk(byte_valid && byte_data == last_rx, "R7", byte_data, last_rx);
               got++;
            end else begin
               chk(!byte_valid, "R7", byte_valid, 0);
            end
         end else begin
            chk(!byte_valid, "R7", byte_valid, 0);
            if (active) begin
               chk(cmd_req && cmd_op == cap_op && cmd_wdata == cap_data, "R11",
                   {cmd_req, cmd_op, cmd_wdata}, {1'b1, cap_op, cap_data});
               cnt--;
               if (cnt == 0) begin
                  cmd_done  = 1'b1;
                  cmd_ack   = 1'b1;
                  cmd_rdata = 8'h5A;
                  case (cls)
                     0: begin
                        cmd_ack = (probe_no >= n_ack);
                        probe_no++;
                        if (cmd_ack) begin phase = 1; ptr_seen = 0; end
                     end
                     1: begin
                        if (ptr_fail_left > 0) begin
                           cmd_ack = 1'b0; ptr_fail_left--; phase = 0;
                        end else begin
                           ptr_seen++;
                           if (ptr_seen == 2) phase = 2;
                        end
                     end
                     2: phase = 3;
                     3: begin
                        last_rx = rx_of(sidx); cmd_rdata = last_rx; sidx++;
                     end
                     default: ;
                  endcase
               end
            end
         end
         chk(eng_en == exp_en, jump_mode ? "R8" : "R9", eng_en, exp_en);
         if (busy_chk) chk(!cmd_req, "R1", cmd_req, 0);
         if (!active && !cmd_done && cmd_req) begin
            cap_op = cmd_op; cap_data = cmd_wdata; active = 1'b1; cnt = LAT;
            if (cmd_op == OP_XFER)      cls = phase;
            else if (cmd_op == OP_STOP) cls = (phase == 3) ? 4 : 5;
            else                        cls = 6;
            if (exp_q.size() == 0) begin
               chk(1'b0, jump_mode ? "R8" : "R9", {cmd_op, cmd_wdata}, 0);
            end else begin
               logic [9:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(cmd_op == e[9:8] && (cmd_op != OP_XFER || cmd_wdata == e[7:0]), t,
                   {cmd_op, cmd_wdata}, e);
            end
         end
      end
   end

   task automatic run_scn(input bit cfg, input int na, input int pf, input int nb,
                          input bit jmp, input int busy_cyc);
      run_on = 0; rst = 1; cfg_slow = cfg; jump_req = 0; ret_req = 0;
      bus_busy = (busy_cyc > 0); cmd_done = 0; cmd_ack = 0; cmd_rdata = 8'h00;
      active = 0; probe_no = 0; n_ack = na; ptr_fail_left = pf; phase = 0;
      ptr_seen = 0; sidx = 0; got = 0; exp_en = 1; jump_mode = jmp; cnt = 0; cls = 6;
      exp_div = cfg ? 8'd160 : 8'd16;
      exp_q.delete(); tag_q.delete();
      build(na, pf, nb, jmp);
      repeat (4) @(negedge clk);
      chk(!cmd_req && !byte_valid && eng_en, "R1", {cmd_req, byte_valid, eng_en}, 3'b001);
      chk(clk_div == exp_div, "R10", clk_div, exp_div);
      rst = 0;
      cfg_slow = !cfg;
      busy_chk = (busy_cyc > 0);
      run_on = 1;
      repeat (busy_cyc) @(negedge clk);
      busy_chk = 0;
      bus_busy = 0;
      while (got < nb) @(negedge clk);
      @(negedge clk);
      if (jmp) jump_req = 1; else ret_req = 1;
      @(negedge clk);
      jump_req = 0; ret_req = 0;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (40) @(negedge clk);
      chk(got == nb + 1, "R7", got, nb + 1);
      chk(eng_en == !jmp, jmp ? "R8" : "R9", eng_en, !jmp);
      chk(!cmd_req, jmp ? "R8" : "R9", cmd_req, 0);
      run_on = 0;
   endtask

   initial begin
      run_scn(1'b0, 3, 0, 5, 1'b1, 30);  // scan to 0x53, jump
      run_scn(1'b1, 0, 1, 3, 1'b0, 0);   // pointer reject and retry, return
      run_scn(1'b0, 9, 0, 2, 1'b1, 5);   // R3 wrap past 0x57, answer at 0x51
      run_scn(1'b1, 8, 0, 1, 1'b0, 0);   // full lap, answer at base again
      run_scn(1'b0, 2, 1, 2, 1'b1, 3);   // R5 retry restarts scan at 0x50
      fin = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         fin = 1;
         total++; bad++;
         $display("FAIL R7 watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule